// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Control

This block holds the hazard and forwarding control for a five-stage in-order pipeline that resolves conditional branches in the decode stage. The branch decision there is an equality (or inequality) test between two operands. The branch target is formed by its own adder next to the comparator. The block reads the two source register numbers of the instruction in decode, plus the destination number, write-enable and load flag of the instructions in EX, EX/MEM and MEM/WB. It then chooses where each comparator operand comes from: the register file, the EX/MEM result or the MEM/WB write-back value. It also evaluates the branch condition on those chosen operands.

There are two outputs to the rest of the pipeline. The first is a single stall line. While it is high, the PC and the IF/ID register hold their values, and every control bit written into ID/EX is zeroed, so a bubble enters EX. The second is a redirect line. It flushes the one instruction in IF/ID and loads the PC with the branch target. An ALU result needed by the next instruction's branch costs one stall cycle. A load result costs two: one while the load is in EX and one while it is in EX/MEM.

The block is purely combinational and carries no data stream, so it has no valid/ready handshake. Every pin is a plain control or operand signal, evaluated in the same cycle.

Top module: `bhz_decode_branch_ctl`

## Requirements
- R1: Each operand select is encoded 0 = register file, 1 = EX/MEM value, 2 = MEM/WB value (3 never appears). An operand selects 1 when its source equals the EX/MEM destination, that stage writes a register and that stage is not a load.
- R2: An operand selects 2 when select 1 does not apply, its source equals the MEM/WB destination, and that stage writes a register.
- R3: Register 0 is never forwarded and never causes a stall. A source of 0 always selects the register file.
- R4: When both EX/MEM (non-load) and MEM/WB match a source, EX/MEM wins.
- R5: With a branch in decode, stall is high when the EX-stage instruction writes a nonzero register equal to either source, whether it is an ALU op or a load. An ALU producer directly ahead of the branch therefore costs exactly one stall cycle.
- R6: With a branch in decode, stall is high when the EX/MEM instruction is a load writing a nonzero register equal to either source. A load directly ahead costs two stall cycles in total; a load two instructions ahead costs one.
- R7: With no branch in decode, stall is high only for a load in EX that writes a nonzero register equal to either source.
- R8: Redirect is high when a branch is in decode, stall is low, and the selected operands are equal (equality branch, id_br_ne = 0) or different (id_br_ne = 1).
- R9: Redirect and stall are never high together.
- R10: With id_branch low, redirect is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_branch | input | 1 | Instruction in decode is a conditional branch |
| id_br_ne | input | 1 | Branch is taken on inequality rather than equality |
| id_src_a | input | AW | First source register number in decode |
| id_src_b | input | AW | Second source register number in decode |
| ex_dst | input | AW | Destination register of the EX-stage instruction |
| ex_wen | input | 1 | EX-stage instruction writes a register |
| ex_load | input | 1 | EX-stage instruction is a load |
| mem_dst | input | AW | Destination register held in EX/MEM |
| mem_wen | input | 1 | EX/MEM instruction writes a register |
| mem_load | input | 1 | EX/MEM instruction is a load |
| wb_dst | input | AW | Destination register held in MEM/WB |
| wb_wen | input | 1 | MEM/WB instruction writes a register |
| rf_a_val | input | DW | Register-file read value for the first source |
| rf_b_val | input | DW | Register-file read value for the second source |
| mem_val | input | DW | ALU result held in EX/MEM |
| wb_val | input | DW | Write-back value held in MEM/WB |
| fwd_a_sel | output | 2 | Operand select for the first comparator input |
| fwd_b_sel | output | 2 | Operand select for the second comparator input |
| stall | output | 1 | Hold PC and IF/ID, bubble into ID/EX |
| redirect | output | 1 | Branch taken: flush IF/ID and load the PC with the target |

## Verification
The bench sweeps every combination of source, destination and flag values with 2-bit register numbers. Operand values are chosen so that both outcomes of the comparison occur with every select. The sweep catches these faults:
- a design that forwards a load's address from EX/MEM, which gives a wrong select under R1;
- one that lets MEM/WB win a double match, which breaks R4;
- one that forwards or stalls on register 0, which raises spurious stalls;
- one that evaluates the branch during a stall, which redirects on stale operands.

Directed pipeline walks count the stall cycles seen by a branch behind an ALU op, behind a load one ahead, and behind a load two ahead. A design that drops the EX/MEM load check would let a branch resolve one cycle early, on a value not yet read from memory.

// File: rtl/bhz_pkg.sv
package bhz_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'd0,
    SEL_EXMEM = 2'd1,
    SEL_MEMWB = 2'd2
  } fwd_sel_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/bhz_fwd_pick.sv
module bhz_fwd_pick
  import bhz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  output fwd_sel_e      sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic src_live;
  logic mem_hit;
  logic wb_hit;

  // A load in EX/MEM holds only an address; its data is not ready yet.
  assign src_live = (src != ZERO_REG);
  assign mem_hit  = src_live && mem_wen && !mem_load && (mem_dst == src);
  assign wb_hit   = src_live && wb_wen && (wb_dst == src);

  always_comb begin
    if (mem_hit)     sel = SEL_EXMEM;
    else if (wb_hit) sel = SEL_MEMWB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/bhz_stall_detect.sv
module bhz_stall_detect #(
  parameter int unsigned AW = 5
) (
  input  logic          id_branch,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_load,
  output logic          stall
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic ex_hit;
  logic mem_hit;
  logic br_ex_wait;
  logic br_mem_wait;
  logic load_use_wait;

  assign ex_hit  = ex_wen && (ex_dst != ZERO_REG) &&
                   ((ex_dst == src_a) || (ex_dst == src_b));
  assign mem_hit = mem_wen && (mem_dst != ZERO_REG) &&
                   ((mem_dst == src_a) || (mem_dst == src_b));

  // Branch compares in decode: any producer still in EX is too late.
  assign br_ex_wait    = id_branch && ex_hit;
  // A load in EX/MEM has no data until it reaches MEM/WB.
  assign br_mem_wait   = id_branch && mem_hit && mem_load;
  // Ordinary instructions wait only for a load directly ahead.
  assign load_use_wait = !id_branch && ex_hit && ex_load;

  assign stall = br_ex_wait || br_mem_wait || load_use_wait;
endmodule

// File: rtl/bhz_branch_cmp.sv
module bhz_branch_cmp
  import bhz_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  fwd_sel_e      sel_a,
  input  fwd_sel_e      sel_b,
  input  logic [DW-1:0] rf_a_val,
  input  logic [DW-1:0] rf_b_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] wb_val,
  input  logic          br_ne,
  output logic          cond
);
  logic [DW-1:0] op_a;
  logic [DW-1:0] op_b;
  logic          same;

  always_comb begin
    case (sel_a)
      SEL_EXMEM: op_a = mem_val;
      SEL_MEMWB: op_a = wb_val;
      default:   op_a = rf_a_val;
    endcase
    case (sel_b)
      SEL_EXMEM: op_b = mem_val;
      SEL_MEMWB: op_b = wb_val;
      default:   op_b = rf_b_val;
    endcase
  end

  assign same = (op_a == op_b);
  assign cond = br_ne ? !same : same;
endmodule

// File: rtl/bhz_decode_branch_ctl.sv
module bhz_decode_branch_ctl
  import bhz_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic          id_branch,
  input  logic          id_br_ne,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic [DW-1:0] rf_a_val,
  input  logic [DW-1:0] rf_b_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] wb_val,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          stall,
  output logic          redirect
);
  logic [AW-1:0] src_vec [NUM_OPS];
  fwd_sel_e      sel_vec [NUM_OPS];
  logic          cond;

  assign src_vec[0] = id_src_a;
  assign src_vec[1] = id_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_pick
    bhz_fwd_pick #(.AW(AW)) u_pick (
      .src      (src_vec[g]),
      .mem_dst  (mem_dst),
      .mem_wen  (mem_wen),
      .mem_load (mem_load),
      .wb_dst   (wb_dst),
      .wb_wen   (wb_wen),
      .sel      (sel_vec[g])
    );
  end

  bhz_stall_detect #(.AW(AW)) u_stall (
    .id_branch (id_branch),
    .src_a     (id_src_a),
    .src_b     (id_src_b),
    .ex_dst    (ex_dst),
    .ex_wen    (ex_wen),
    .ex_load   (ex_load),
    .mem_dst   (mem_dst),
    .mem_wen   (mem_wen),
    .mem_load  (mem_load),
    .stall     (stall)
  );

  bhz_branch_cmp #(.DW(DW)) u_cmp (
    .sel_a    (sel_vec[0]),
    .sel_b    (sel_vec[1]),
    .rf_a_val (rf_a_val),
    .rf_b_val (rf_b_val),
    .mem_val  (mem_val),
    .wb_val   (wb_val),
    .br_ne    (id_br_ne),
    .cond     (cond)
  );

  assign fwd_a_sel = sel_vec[0];
  assign fwd_b_sel = sel_vec[1];
  // Flush of IF/ID and PC load only once operands are final.
  assign redirect  = id_branch && !stall && cond;
endmodule

// File: rtl/bhz_decode_branch_ctl_chk.sv
module bhz_decode_branch_ctl_chk #(
  parameter int unsigned AW = 5
) (
  input logic          id_branch,
  input logic [AW-1:0] id_src_a,
  input logic [AW-1:0] id_src_b,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [1:0]    fwd_a_sel,
  input logic [1:0]    fwd_b_sel,
  input logic          stall,
  input logic          redirect
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    a_r9_redirect_excludes_stall: assert (!(stall && redirect))
      else $error("redirect raised during stall");
    a_r10_idle_no_redirect: assert (id_branch || !redirect)
      else $error("redirect without branch");
    a_r1_select_encoding: assert ((fwd_a_sel != 2'd3) && (fwd_b_sel != 2'd3))
      else $error("illegal select code");
    a_r3_zero_reg_from_rf: assert (((id_src_a != ZERO_REG) || (fwd_a_sel == 2'd0)) &&
                                   ((id_src_b != ZERO_REG) || (fwd_b_sel == 2'd0)))
      else $error("register zero forwarded");
    a_r7_plain_stall_is_load: assert (id_branch || !stall || (ex_wen && ex_load))
      else $error("non-branch stall without load in EX");
  end
endmodule

bind bhz_decode_branch_ctl bhz_decode_branch_ctl_chk #(.AW(AW)) u_chk (
  .id_branch (id_branch),
  .id_src_a  (id_src_a),
  .id_src_b  (id_src_b),
  .ex_wen    (ex_wen),
  .ex_load   (ex_load),
  .fwd_a_sel (fwd_a_sel),
  .fwd_b_sel (fwd_b_sel),
  .stall     (stall),
  .redirect  (redirect)
);

// File: tb/sim_bhz_decode_branch_ctl.sv
`timescale 1ns/1ps
module sim_bhz_decode_branch_ctl;
  localparam int unsigned AW = 2;
  localparam int unsigned DW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          id_branch, id_br_ne;
  logic [AW-1:0] id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;
  logic          ex_wen, ex_load, mem_wen, mem_load, wb_wen;
  logic [DW-1:0] rf_a_val, rf_b_val, mem_val, wb_val;
  logic [1:0]    fwd_a_sel, fwd_b_sel;
  logic          stall, redirect;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bhz_decode_branch_ctl #(.AW(AW), .DW(DW)) u0 (
    .id_branch(id_branch), .id_br_ne(id_br_ne),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .rf_a_val(rf_a_val), .rf_b_val(rf_b_val),
    .mem_val(mem_val), .wb_val(wb_val),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .stall(stall), .redirect(redirect)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(input logic [AW-1:0] s);
    if (s != 0 && mem_wen && !mem_load && mem_dst == s) return 1;
    if (s != 0 && wb_wen && wb_dst == s) return 2;
    return 0;
  endfunction

  function automatic bit hits(input logic [AW-1:0] d);
    return (d != 0) && (d == id_src_a || d == id_src_b);
  endfunction

  function automatic bit exp_stall();
    if (id_branch) return (ex_wen && hits(ex_dst)) || (mem_wen && mem_load && hits(mem_dst));
    return ex_wen && ex_load && hits(ex_dst);
  endfunction

  function automatic logic [DW-1:0] pick(input int sel, input logic [DW-1:0] rf);
    return (sel == 1) ? mem_val : (sel == 2) ? wb_val : rf;
  endfunction

  function automatic bit exp_redirect();
    logic [DW-1:0] a, b;
    a = pick(exp_sel(id_src_a), rf_a_val);
    b = pick(exp_sel(id_src_b), rf_b_val);
    if (!id_branch || exp_stall()) return 1'b0;
    return id_br_ne ? (a != b) : (a == b);
  endfunction

  task automatic idle();
    {id_branch, id_br_ne, ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
    {id_src_a, id_src_b, ex_dst, mem_dst, wb_dst} = '0;
    rf_a_val = 4'd7; rf_b_val = 4'd7; mem_val = 4'd1; wb_val = 4'd2;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    idle();
    step();
    check("R10 idle redirect", int'(redirect), 0);
    check("R7 idle stall", int'(stall), 0);
    check("R1 idle select a", int'(fwd_a_sel), 0);

    // Exhaustive sweep
    for (int i = 0; i < 131072; i++) begin
      @(posedge clk);
      id_branch = i[0];   id_br_ne = i[1];
      id_src_a  = i[3:2]; id_src_b = i[5:4];
      ex_dst    = i[7:6]; ex_wen   = i[8];  ex_load  = i[9];
      mem_dst   = i[11:10]; mem_wen = i[12]; mem_load = i[13];
      wb_dst    = i[15:14]; wb_wen  = i[16];
      rf_a_val  = 4'd5;
      rf_b_val  = i[2]  ? 4'd5 : 4'd9;
      mem_val   = i[6]  ? 4'd5 : 4'd3;
      wb_val    = i[10] ? 4'd5 : 4'd12;
      step();
      check("R1 R2 R3 R4 select a", int'(fwd_a_sel), exp_sel(id_src_a));
      check("R1 R2 R3 R4 select b", int'(fwd_b_sel), exp_sel(id_src_b));
      check("R5 R6 R7 stall", int'(stall), int'(exp_stall()));
      check("R8 R9 R10 redirect", int'(redirect), int'(exp_redirect()));
    end

    // R5: ALU op then branch on its result -> one stall cycle
    begin
      int stalls = 0;
      idle(); @(posedge clk);
      id_branch = 1; id_src_a = 2'd1; id_src_b = 2'd2;
      ex_dst = 2'd1; ex_wen = 1; step(); stalls += int'(stall);
      @(posedge clk); ex_wen = 0; mem_dst = 2'd1; mem_wen = 1; mem_val = 4'd7; rf_b_val = 4'd7;
      step(); stalls += int'(stall);
      check("R5 ALU stall count", stalls, 1);
      check("R5 ALU operand from EX/MEM", int'(fwd_a_sel), 1);
      check("R8 taken after ALU forward", int'(redirect), 1);
    end

    // R6: load directly ahead -> two stall cycles
    begin
      int stalls = 0;
      idle(); @(posedge clk);
      id_branch = 1; id_src_a = 2'd3; id_src_b = 2'd0;
      ex_dst = 2'd3; ex_wen = 1; ex_load = 1; step(); stalls += int'(stall);
      @(posedge clk); ex_wen = 0; ex_load = 0; mem_dst = 2'd3; mem_wen = 1; mem_load = 1;
      step(); stalls += int'(stall);
      check("R9 no redirect while stalled", int'(redirect), 0);
      @(posedge clk); mem_wen = 0; mem_load = 0; wb_dst = 2'd3; wb_wen = 1; wb_val = 4'd6;
      rf_b_val = 4'd6; id_br_ne = 1;
      step(); stalls += int'(stall);
      check("R6 load stall count", stalls, 2);
      check("R6 load operand from MEM/WB", int'(fwd_a_sel), 2);
      check("R8 ne branch not taken on equal", int'(redirect), 0);
    end

    // R6: load two ahead already in EX/MEM -> one stall
    begin
      int stalls = 0;
      idle(); @(posedge clk);
      id_branch = 1; id_src_b = 2'd2;
      mem_dst = 2'd2; mem_wen = 1; mem_load = 1; step(); stalls += int'(stall);
      @(posedge clk); mem_wen = 0; mem_load = 0; wb_dst = 2'd2; wb_wen = 1;
      step(); stalls += int'(stall);
      check("R6 distant load stall count", stalls, 1);
    end

    // R3 and R4 directed
    idle(); @(posedge clk);
    id_branch = 1; ex_dst = 0; ex_wen = 1; mem_wen = 1; wb_wen = 1;
    step();
    check("R3 zero reg no stall", int'(stall), 0);
    @(posedge clk); id_src_a = 2'd1; mem_dst = 2'd1; wb_dst = 2'd1; ex_wen = 0;
    step();
    check("R4 EX/MEM priority", int'(fwd_a_sel), 1);
    @(posedge clk); id_branch = 0; ex_dst = 2'd1; ex_wen = 1; ex_load = 0;
    step();
    check("R7 non-branch ALU no stall", int'(stall), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule